// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level requests from up to 31 peripheral sources and turns them into a single level-sensitive interrupt line toward the processor, together with a three-bit field that says on which processor interrupt level that line is to be taken. Software programs it through four 32-bit registers: configuration, mask, in-service and vector. The registers sit on a simple one-cycle write port with a combinational read path.

To service an interrupt, software writes the acknowledge bit of the vector register. The block then resolves the highest-priority request that is pending, enabled and not already in service. It latches that source number, returns it in bits 15:11 of the vector register, and marks the source in service. Software ends servicing by writing a 1 to the source's bit in the in-service register. A request can be withdrawn or masked after the line was raised and before the acknowledge lands. The acknowledge then yields the error vector 31, which sets no in-service bit and needs no further handling.

Priority is fixed, and the lower number wins, with two exceptions. Configuration can promote any one source above all others. Configuration can also rotate the order inside a group of four serial-channel sources, which occupy numbers SER_BASE to SER_BASE+3 (26 to 29 by default).

Top module: `vpic_top`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read zero, `irq_out` is low and `irq_level` is 0.
- R2: Mask register bit n (address 1) set to 1 lets source n take part; a masked source never raises `irq_out` and is never returned by an acknowledge.
- R3: Configuration bit 0 (address 0) is the global enable; while it is 0, `irq_out` is low one cycle later, whatever the requests.
- R4: Configuration bits 15:13 appear on `irq_level` in the cycle after they are written.
- R5: With the global enable set, `irq_out` is high one cycle after some source is requesting, unmasked and not in service, and low one cycle after no such source exists.
- R6: Writing the vector register (address 3) with bit 0 = 1 latches the winning source number; reads of address 3 return it in bits 15:11 with all other bits 0, and the winner's in-service bit (address 2) becomes 1.
- R7: Without promotion or rotation, the lowest-numbered eligible source wins.
- R8: With configuration bit 1 set, the source numbered in configuration bits 12:8 wins over every other eligible source.
- R9: Configuration bits 3:2 hold a rotation r; within the serial group the order starts at SER_BASE+r and continues upward, wrapping modulo 4.
- R10: Writing 1 to an in-service bit clears it and writing 0 leaves it unchanged; a source in service is not chosen again, and its still-held request is chosen after its bit is cleared.
- R11: An acknowledge that finds no eligible source, for example because the request dropped or was masked in the same cycle, latches vector 31 and changes no in-service bit.
- R12: A write to the vector register with bit 0 = 0 changes neither the vector nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_req | input | NSRC (31) | Level request, one bit per source |
| irq_out | output | 1 | Level interrupt to the processor |
| irq_level | output | 3 | Processor interrupt level selected by configuration |

## Verification
The acknowledge and the withdrawal of a request can fall in the same clock cycle. The bench first waits for `irq_out` to rise for a single source. In one cycle it then drops that request and issues the acknowledge write. It expects the vector register to read 31 and the in-service register to stay zero, because the block must resolve the acknowledge against the request level present at that edge. It does the same with the source masked instead of withdrawn, and it checks that an acknowledge with a held request still marks exactly one source.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int unsigned VEC_W   = 5;
    localparam logic [VEC_W-1:0] ERR_VEC = '1;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_MASK = 2'd1,
        A_INSV = 2'd2,
        A_VEC  = 2'd3
    } reg_addr_e;

    // Configuration layout: level field at 15:13 drives the processor side
    typedef struct packed {
        logic [2:0]       level;
        logic [VEC_W-1:0] prom_src;
        logic [3:0]       rsvd;
        logic [1:0]       rot;
        logic             prom_en;
        logic             gen_en;
    } cfg_t;

endpackage

// File: rtl/vpic_prio.sv
module vpic_prio
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC     = 31,
    parameter int unsigned SER_BASE = 26
) (
    input  logic [NSRC-1:0]  elig,
    input  logic             prom_en,
    input  logic [VEC_W-1:0] prom_src,
    input  logic [1:0]       rot,
    output logic             any,
    output logic [VEC_W-1:0] win
);

    localparam int unsigned GRP_N = 4;

    // Source placed at priority position p (position 0 is highest)
    function automatic int unsigned pos2src(input int unsigned p, input logic [1:0] r);
        if (p >= SER_BASE && p < SER_BASE + GRP_N)
            return SER_BASE + ((p - SER_BASE + int'(r)) % GRP_N);
        return p;
    endfunction

    logic [NSRC-1:0] ordered;
    logic            found;
    logic [VEC_W-1:0] fixed_win;

    always_comb begin
        for (int p = 0; p < NSRC; p++) begin
            ordered[p] = elig[pos2src(p, rot)];
        end
    end

    always_comb begin
        found     = 1'b0;
        fixed_win = '0;
        for (int p = NSRC - 1; p >= 0; p--) begin
            if (ordered[p]) begin
                found     = 1'b1;
                fixed_win = VEC_W'(pos2src(p, rot));
            end
        end
    end

    always_comb begin
        any = found;
        win = fixed_win;
        if (prom_en && (int'(prom_src) < NSRC) && elig[prom_src]) begin
            win = prom_src;
        end
    end

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic             any,
    input  logic [VEC_W-1:0] win,
    output cfg_t             cfg_q,
    output logic [NSRC-1:0]  mask_q,
    output logic [NSRC-1:0]  insv_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             irq_q
);

    typedef struct packed {
        cfg_t             cfg;
        logic [NSRC-1:0]  mask;
        logic [NSRC-1:0]  insv;
        logic [VEC_W-1:0] vec;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = st_q.cfg.gen_en & any;
        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                A_CFG:  st_d.cfg  = cfg_t'(bus_wdata[15:0]);
                A_MASK: st_d.mask = bus_wdata[NSRC-1:0];
                A_INSV: st_d.insv = st_q.insv & ~bus_wdata[NSRC-1:0];
                A_VEC: begin
                    if (bus_wdata[0]) begin
                        if (any) begin
                            st_d.vec       = win;
                            st_d.insv[win] = 1'b1;
                        end else begin
                            st_d.vec = ERR_VEC;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q  = st_q.cfg;
    assign mask_q = st_q.mask;
    assign insv_q = st_q.insv;
    assign vec_q  = st_q.vec;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC     = 31,
    parameter int unsigned SER_BASE = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] src_req,
    output logic            irq_out,
    output logic [2:0]      irq_level
);

    cfg_t             cfg_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  insv_q;
    logic [VEC_W-1:0] vec_q;
    logic             irq_q;
    logic [NSRC-1:0]  elig;
    logic             any_elig;
    logic [VEC_W-1:0] win;
    logic             ack_wr;

    assign elig   = src_req & mask_q & ~insv_q;
    assign ack_wr = bus_wr && (reg_addr_e'(bus_addr) == A_VEC) && bus_wdata[0];

    vpic_prio #(.NSRC(NSRC), .SER_BASE(SER_BASE)) prio_i (
        .elig     (elig),
        .prom_en  (cfg_q.prom_en),
        .prom_src (cfg_q.prom_src),
        .rot      (cfg_q.rot),
        .any      (any_elig),
        .win      (win)
    );

    vpic_regs #(.NSRC(NSRC)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .any       (any_elig),
        .win       (win),
        .cfg_q     (cfg_q),
        .mask_q    (mask_q),
        .insv_q    (insv_q),
        .vec_q     (vec_q),
        .irq_q     (irq_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            A_CFG:  bus_rdata[15:0]      = cfg_q;
            A_MASK: bus_rdata[NSRC-1:0]  = mask_q;
            A_INSV: bus_rdata[NSRC-1:0]  = insv_q;
            A_VEC:  bus_rdata[15:11]     = vec_q;
            default: ;
        endcase
    end

    assign irq_out   = irq_q;
    assign irq_level = cfg_q.level;

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             ack_wr,
    input logic             any_elig,
    input logic             gen_en,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  insv_q,
    input logic [VEC_W-1:0] vec_q,
    input logic             irq_out
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !irq_out); // R3

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && any_elig) |=> irq_out); // R5

    AST_ACK_MARKS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && any_elig) |=> ($countones(insv_q) == $past($countones(insv_q)) + 1)); // R6

    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && any_elig) |=> ((int'(vec_q) < NSRC) && mask_q[vec_q])); // R2

    AST_ERR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !any_elig) |=> ((vec_q == ERR_VEC) && $stable(insv_q))); // R11

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_INSV) |=> ((insv_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R10

    AST_NO_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_VEC && !bus_wdata[0]) |=> ($stable(vec_q) && $stable(insv_q))); // R12

endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ack_wr    (ack_wr),
    .any_elig  (any_elig),
    .gen_en    (cfg_q.gen_en),
    .mask_q    (mask_q),
    .insv_q    (insv_q),
    .vec_q     (vec_q),
    .irq_out   (irq_out)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

    localparam int NSRC = 31;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic            irq_out;
    logic [2:0]      irq_level;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    vpic_top #(.NSRC(NSRC), .SER_BASE(26)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_req   (src_req),
        .irq_out   (irq_out),
        .irq_level (irq_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack_expect(input string tag, input int exp_vec);
        logic [31:0] v;
        wr(2'd3, 32'h1);
        rd(2'd3, v);
        chk(tag, v, 32'(exp_vec) << 11);
    endtask

    task automatic clean();
        src_req = '0;
        wr(2'd2, 32'hFFFF_FFFF);
        idle(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset value", v, 32'h0);
        end
        chk("R1 irq_out low", 32'(irq_out), 32'h0);
        chk("R1 irq_level zero", 32'(irq_level), 32'h0);
    endtask

    task automatic t_enable_mask();
        logic [31:0] v;
        wr(2'd1, 32'h1 << 5);
        rd(2'd1, v);
        chk("R2 mask readback", v, 32'h20);
        src_req[5] = 1'b1;
        idle(2);
        chk("R3 irq low while disabled", 32'(irq_out), 32'h0);
        wr(2'd0, 32'h1);
        idle(1);
        chk("R5 irq high when enabled", 32'(irq_out), 32'h1);
        wr(2'd1, 32'h0);
        idle(1);
        chk("R2 masked source drops irq", 32'(irq_out), 32'h0);
        src_req[5] = 1'b0;
        idle(1);
    endtask

    task automatic t_level();
        wr(2'd0, 32'h1 | (32'h5 << 13));
        chk("R4 level field on output", 32'(irq_level), 32'h5);
        wr(2'd0, 32'h1);
    endtask

    task automatic t_fixed_inservice();
        logic [31:0] v;
        wr(2'd1, 32'h7FFF_FFFF);
        src_req[3] = 1'b1; src_req[7] = 1'b1; src_req[20] = 1'b1;
        idle(2);
        ack_expect("R7 lowest number wins", 3);
        rd(2'd2, v);
        chk("R6 in-service set by ack", v, 32'h8);
        ack_expect("R10 in-service source skipped", 7);
        wr(2'd2, 32'h0);
        rd(2'd2, v);
        chk("R10 write zero keeps in-service", v, 32'h88);
        wr(2'd2, 32'h8);
        rd(2'd2, v);
        chk("R10 write one clears in-service", v, 32'h80);
        ack_expect("R10 held request presented again", 3);
        clean();
    endtask

    task automatic t_promote();
        wr(2'd0, 32'h1 | 32'h2 | (32'd20 << 8));
        src_req[3] = 1'b1; src_req[20] = 1'b1;
        idle(2);
        ack_expect("R8 promoted source wins", 20);
        ack_expect("R8 then fixed order", 3);
        clean();
        wr(2'd0, 32'h1);
    endtask

    task automatic t_serial();
        wr(2'd0, 32'h1 | (32'h2 << 2));
        for (int s = 26; s < 30; s++) src_req[s] = 1'b1;
        idle(2);
        ack_expect("R9 rotated group first", 28);
        ack_expect("R9 rotated group second", 29);
        ack_expect("R9 rotated group wraps", 26);
        ack_expect("R9 rotated group last", 27);
        clean();
        wr(2'd0, 32'h1);
    endtask

    task automatic t_error_race();
        logic [31:0] v;
        src_req[4] = 1'b1;
        idle(2);
        chk("R5 irq before race", 32'(irq_out), 32'h1);
        @(negedge clk);
        src_req[4] = 1'b0;
        bus_addr   = 2'd3;
        bus_wdata  = 32'h1;
        bus_wr     = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(2'd3, v);
        chk("R11 withdrawn request gives error vector", v, 32'd31 << 11);
        rd(2'd2, v);
        chk("R11 error vector sets no in-service", v, 32'h0);
        src_req[4] = 1'b1;
        wr(2'd1, 32'h0);
        ack_expect("R11 masked request gives error vector", 31);
        rd(2'd2, v);
        chk("R11 in-service untouched after mask race", v, 32'h0);
    endtask

    task automatic t_no_ack();
        logic [31:0] v;
        wr(2'd1, 32'h7FFF_FFFF);
        idle(1);
        wr(2'd3, 32'hFFFF_FFFE);
        rd(2'd3, v);
        chk("R12 vector unchanged without ack bit", v, 32'd31 << 11);
        rd(2'd2, v);
        chk("R12 in-service unchanged without ack bit", v, 32'h0);
        clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_enable_mask();
        t_level();
        t_fixed_inservice();
        t_promote();
        t_serial();
        t_error_race();
        t_no_ack();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule